// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block watches for software that has stopped running normally. A prescaler divides the CPU clock and sends enable pulses to a down-counter of `CNT_W` bits. Software services the watchdog by strobing a service write, which reloads the counter with all ones. If the counter runs out, the block does one of two things. In interrupt mode it raises a one-cycle interrupt request, reloads and keeps counting. In reset mode it drives an active-low internal reset for a fixed number of cycles.

After a system reset the block is idle and nothing counts. The first service write starts it. The prescaler ratio depends on which clock drives the CPU and on a select bit. The mode bit can only be set by software, never cleared. Both the prescaler and the counter hold their values while the chip is in stop or wait mode.

Top module: `wdog_unit`

## Requirements
- R1: After system reset, `irq` is 0 and `rst_req_n` is 1, and they stay that way (no counting) until the first accepted service write, whatever the other inputs do.
- R2: An accepted `svc_wr` loads the counter with all ones (0x7FFF for the default `CNT_W` of 15) and starts the watchdog. From a cleared prescaler, the first underflow comes exactly ratio × 2^CNT_W cycles after that write.
- R3: When `cpu_src` is 2'b00 (main), 2'b01 (PLL) or 2'b10 (on-chip oscillator), the ratio is `DIV_LO` (16) when `div_sel` is 0 and `DIV_HI` (128) when `div_sel` is 1.
- R4: When `cpu_src` is 2'b11 (sub-clock), the ratio is `DIV_SUB` (2), whatever `div_sel` is.
- R5: In interrupt mode, an underflow gives a one-cycle `irq` pulse in the cycle after the underflowing prescaler pulse. The counter reloads and keeps running, so the next pulse follows ratio × 2^CNT_W cycles later.
- R6: A `mode_wr` with `mode_wdata` = 1 selects reset mode. A `mode_wr` with `mode_wdata` = 0 never clears the bit.
- R7: In reset mode, an underflow drives `rst_req_n` low for exactly `RST_LEN` (4) cycles, starting the cycle after the underflowing pulse, with no `irq`. Afterwards the block is idle again, with the mode bit cleared and the prescaler cleared.
- R8: While `stop_mode` or `wait_mode` is 1, the prescaler and the counter hold their values. When both flags return to 0, counting resumes from those held values, so the underflow comes later by exactly the frozen cycle count.
- R9: Service writes do not clear the prescaler. A write made p cycles into a prescaler interval shortens the following period by p cycles.
- R10: A service write in the same cycle as an underflowing prescaler pulse wins. It reloads the counter, and neither `irq` nor a reset follows.
- R11: While `rst_req_n` is low, `svc_wr` and `mode_wr` are ignored.
- R12: If the ratio changes to a value at or below the prescaler's current count, the next enabled cycle produces a pulse and the prescaler restarts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | System reset, asynchronous, active low |
| cpu_src | input | 2 | CPU clock source: 00 main, 01 PLL, 10 on-chip oscillator, 11 sub-clock |
| div_sel | input | 1 | Prescaler select when the source is not the sub-clock: 0 low ratio, 1 high ratio |
| svc_wr | input | 1 | Service write strobe |
| mode_wr | input | 1 | Mode bit write strobe |
| mode_wdata | input | 1 | Mode write data: 1 selects reset mode |
| stop_mode | input | 1 | Stop mode flag; freezes counting |
| wait_mode | input | 1 | Wait mode flag; freezes counting |
| irq | output | 1 | One-cycle interrupt request on underflow in interrupt mode |
| rst_req_n | output | 1 | Active-low internal reset request on underflow in reset mode |

## Verification
Every internal error in this block shows up at the ports as a shift in when `irq` or the `rst_req_n` pulse appears, or as an event that should not happen. A wrong prescaler phase or ratio moves the first event by whole prescaler intervals. A counter that is not reloaded, or that misses a freeze, moves it by ratio × 2^CNT_W cycles or by the frozen span. Because of this, the bench builds with a 6-bit counter so that each fault shows within a few thousand cycles. It compares both outputs on every cycle against a model built from the requirements. A mode bit that wrongly clears or sets shows at the next underflow as the wrong kind of event. A missing return to idle after the reset pulse shows within one period as an unexpected event.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // CPU clock source code on the cpu_src pins
  typedef enum logic [1:0] {
    SRC_MAIN   = 2'b00,
    SRC_PLL    = 2'b01,
    SRC_ONCHIP = 2'b10,
    SRC_SUB    = 2'b11
  } cpu_src_e;

endpackage

// File: rtl/wdog_prescale.sv
// Divides the CPU clock into count-enable pulses; ratio chosen by source and select.
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int DIV_LO  = 16,
  parameter int DIV_HI  = 128,
  parameter int DIV_SUB = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] src,
  input  logic       div_sel,
  output logic       tick_o
);

  localparam int PW = $clog2(DIV_HI);
  localparam logic [PW-1:0] LO_M1  = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] HI_M1  = PW'(DIV_HI - 1);
  localparam logic [PW-1:0] SUB_M1 = PW'(DIV_SUB - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] ratio_m1;

  always_comb begin
    if (cpu_src_e'(src) == SRC_SUB) begin
      ratio_m1 = SUB_M1;                 // R4: sub-clock ignores div_sel
    end else begin
      ratio_m1 = div_sel ? HI_M1 : LO_M1; // R3
    end
  end

  // R12: ">=" so a ratio that drops below the current phase fires at once
  assign tick_o = run && (pre_q >= ratio_m1);

  always_comb begin
    pre_d = pre_q;
    if (clr) begin
      pre_d = '0;
    end else if (run) begin
      pre_d = tick_o ? '0 : pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/wdog_downcnt.sv
// Down-counter with service reload and underflow detect.
module wdog_downcnt #(
  parameter int CNT_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic tick,
  output logic uf_o
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // R10: a load in the same cycle masks the underflow
  assign uf_o = tick && (cnt_q == '0) && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || load) begin
      cnt_d = TOP;                        // R2
    end else if (tick) begin
      cnt_d = (cnt_q == '0) ? TOP : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TOP;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/wdog_mode_latch.sv
// Set-only underflow action bit: 0 interrupt, 1 reset.
module wdog_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr,
  input  logic wdata,
  output logic mode_o
);

  logic mode_q, mode_d;

  always_comb begin
    if (clr) begin
      mode_d = 1'b0;                      // R7: internal reset clears it
    end else begin
      mode_d = mode_q | (wr & wdata);     // R6: set only
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/wdog_action.sv
// Run state, interrupt pulse and internal reset pulse.
module wdog_action #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc,
  input  logic fire_irq,
  input  logic fire_rst,
  output logic started_o,
  output logic irq_o,
  output logic pulse_o,
  output logic clr_o
);

  localparam int RCW = $clog2(RST_LEN + 1);

  logic [RCW-1:0] rc_q, rc_d;
  logic           started_q, started_d;
  logic           irq_q, irq_d;

  assign pulse_o = (rc_q != '0);
  assign clr_o   = fire_rst || pulse_o;

  always_comb begin
    rc_d = rc_q;
    if (fire_rst) begin
      rc_d = RCW'(RST_LEN);               // R7
    end else if (pulse_o) begin
      rc_d = rc_q - RCW'(1);
    end
  end

  always_comb begin
    if (clr_o) begin
      started_d = 1'b0;                   // back to idle
    end else begin
      started_d = started_q | svc;        // R1/R2
    end
  end

  assign irq_d = fire_irq;                // R5: registered single pulse

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q      <= '0;
      started_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rc_q      <= rc_d;
      started_q <= started_d;
      irq_q     <= irq_d;
    end
  end

  assign started_o = started_q;
  assign irq_o     = irq_q;

endmodule

// File: rtl/wdog_unit.sv
module wdog_unit #(
  parameter int CNT_W   = 15,
  parameter int DIV_LO  = 16,
  parameter int DIV_HI  = 128,
  parameter int DIV_SUB = 2,
  parameter int RST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cpu_src,
  input  logic       div_sel,
  input  logic       svc_wr,
  input  logic       mode_wr,
  input  logic       mode_wdata,
  input  logic       stop_mode,
  input  logic       wait_mode,
  output logic       irq,
  output logic       rst_req_n
);

  logic pulse, clr_all, started_q, mode_q;
  logic svc_ok, mode_wr_ok, run, tick, uf_evt;
  logic fire_irq, fire_rst;

  // R11: writes are dropped while the internal reset is driven
  assign svc_ok     = svc_wr  && !pulse;
  assign mode_wr_ok = mode_wr && !pulse;

  // R8: low-power flags freeze prescaler and counter together
  assign run = started_q && !(stop_mode || wait_mode);

  assign fire_irq = uf_evt && !mode_q;
  assign fire_rst = uf_evt &&  mode_q;

  wdog_prescale #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI),
    .DIV_SUB(DIV_SUB)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_all),
    .run    (run),
    .src    (cpu_src),
    .div_sel(div_sel),
    .tick_o (tick)
  );

  wdog_downcnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_all),
    .load (svc_ok),
    .tick (tick),
    .uf_o (uf_evt)
  );

  wdog_mode_latch u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .wr    (mode_wr_ok),
    .wdata (mode_wdata),
    .mode_o(mode_q)
  );

  wdog_action #(
    .RST_LEN(RST_LEN)
  ) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc      (svc_ok),
    .fire_irq (fire_irq),
    .fire_rst (fire_rst),
    .started_o(started_q),
    .irq_o    (irq),
    .pulse_o  (pulse),
    .clr_o    (clr_all)
  );

  assign rst_req_n = !pulse;

endmodule

// File: rtl/wdog_unit_chk.sv
module wdog_unit_chk #(
  parameter int RST_LEN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic svc_wr,
  input logic stop_mode,
  input logic wait_mode,
  input logic irq,
  input logic rst_req_n,
  input logic started_q,
  input logic mode_q,
  input logic uf_evt
);

  logic [7:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (!rst_req_n) begin
      low_q <= low_q + 8'd1;
    end else begin
      low_q <= '0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |=> !irq);

  p_svc_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && rst_req_n) |=> started_q);

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_mode_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !uf_evt) |=> mode_q);

  p_rst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_n && (low_q != '0)) |-> (low_q == 8'(RST_LEN)));

  p_rst_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n |-> (low_q < 8'(RST_LEN)));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode || wait_mode) |-> !uf_evt);

  p_svc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && rst_req_n) |=> (!irq && rst_req_n));

  p_ignore_in_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n |=> !mode_q);

endmodule

bind wdog_unit wdog_unit_chk #(
  .RST_LEN(RST_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .svc_wr   (svc_wr),
  .stop_mode(stop_mode),
  .wait_mode(wait_mode),
  .irq      (irq),
  .rst_req_n(rst_req_n),
  .started_q(started_q),
  .mode_q   (mode_q),
  .uf_evt   (uf_evt)
);

// File: tb/test_wdog_unit.sv
`timescale 1ns/1ps
module test_wdog_unit;

  localparam int W    = 6;
  localparam int MAXV = (1 << W) - 1;
  localparam int SPAN = 1 << W;
  localparam int RLEN = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, div_sel, svc_wr, mode_wr, mode_wdata, stop_mode, wait_mode;
  logic [1:0] cpu_src;
  logic       irq, rst_req_n;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  bit m_started, m_mode, m_irq;
  int m_pre, m_cnt, m_rc;

  wdog_unit #(.CNT_W(W), .DIV_LO(16), .DIV_HI(128), .DIV_SUB(2), .RST_LEN(RLEN)) i_wdog_unit (
    .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .div_sel(div_sel), .svc_wr(svc_wr),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .stop_mode(stop_mode),
    .wait_mode(wait_mode), .irq(irq), .rst_req_n(rst_req_n)
  );

  function automatic int ratio_of(logic [1:0] s, logic d);
    if (s == 2'b11) return 2;       // R4
    return d ? 128 : 16;            // R3
  endfunction

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_started = 0; m_mode = 0; m_irq = 0; m_pre = 0; m_cnt = MAXV; m_rc = 0;
  endtask

  task automatic model_step();
    bit pulse, svc, run, tk, uf;
    int r;
    pulse = (m_rc != 0);
    svc   = svc_wr && !pulse;
    r     = ratio_of(cpu_src, div_sel);
    run   = m_started && !(stop_mode || wait_mode);
    tk    = run && (m_pre >= r - 1);
    uf    = tk && (m_cnt == 0) && !svc;
    m_irq = uf && !m_mode;
    if (pulse || (uf && m_mode)) begin
      m_rc = pulse ? m_rc - 1 : RLEN;
      m_started = 0; m_mode = 0; m_pre = 0; m_cnt = MAXV;
    end else begin
      if (run) m_pre = tk ? 0 : m_pre + 1;
      if (svc) m_cnt = MAXV;
      else if (tk) m_cnt = (m_cnt == 0) ? MAXV : m_cnt - 1;
      m_started = m_started || svc;
      m_mode = m_mode || (mode_wr && mode_wdata);
    end
  endtask

  // one clock: model advances with the current inputs, outputs compared after the edge
  task automatic cyc();
    model_step();
    @(negedge clk);
    check("R5/R7 model irq", int'(irq), int'(m_irq));
    check("R5/R7 model rst_req_n", int'(rst_req_n), int'(m_rc == 0));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; svc_wr = 0; mode_wr = 0; mode_wdata = 0;
    stop_mode = 0; wait_mode = 0; cpu_src = 2'b00; div_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic svc_once();
    svc_wr = 1; cyc(); svc_wr = 0;
  endtask

  task automatic meas(input int limit, output int k);
    k = 0;
    while (k < limit) begin
      cyc(); k++;
      if (irq || !rst_req_n) break;
    end
  endtask

  task automatic idle_watch(input int n, output int ev);
    ev = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (irq || !rst_req_n) ev++;
    end
  endtask

  initial begin
    int k, ev, lows;
    void'($urandom(32'h5EED_0042));
    rst_n = 1; svc_wr = 0; mode_wr = 0; mode_wdata = 0;
    stop_mode = 0; wait_mode = 0; cpu_src = 2'b00; div_sel = 0;
    do_reset();

    // R1: reset state and idleness without a service write
    check("R1 irq after reset", int'(irq), 0);
    check("R1 rst_req_n after reset", int'(rst_req_n), 1);
    cpu_src = 2'b11; mode_wr = 1; mode_wdata = 1; cyc(); mode_wr = 0;
    idle_watch(400, ev);
    check("R1 no event while unstarted", ev, 0);

    // R2/R3: main clock, low ratio
    do_reset();
    svc_once(); meas(20000, k);
    check("R2/R3 first period main div16", k, 16 * SPAN);
    check("R5 irq after underflow", int'(irq), 1);
    cyc();
    check("R5 irq lasts one cycle", int'(irq), 0);
    meas(20000, k);
    check("R5 next period after reload", k + 1, 16 * SPAN);

    // R3: high ratio
    do_reset(); div_sel = 1;
    svc_once(); meas(20000, k);
    check("R3 period main div128", k, 128 * SPAN);

    // R3: PLL and on-chip sources behave as main
    do_reset(); cpu_src = 2'b01;
    svc_once(); meas(20000, k);
    check("R3 period pll div16", k, 16 * SPAN);
    do_reset(); cpu_src = 2'b10;
    svc_once(); meas(20000, k);
    check("R3 period onchip div16", k, 16 * SPAN);

    // R4: sub clock ignores div_sel
    do_reset(); cpu_src = 2'b11; div_sel = 1;
    svc_once(); meas(20000, k);
    check("R4 period sub div2", k, 2 * SPAN);

    // R9: second service write mid-interval keeps prescaler phase
    do_reset();
    svc_once(); repeat (9) cyc();
    svc_once(); meas(20000, k);
    check("R9 shortened period", k, 16 * SPAN - 10);

    // R8: stop then wait freeze, counting resumes
    do_reset();
    svc_once(); repeat (100) cyc();
    stop_mode = 1; repeat (300) cyc(); stop_mode = 0;
    wait_mode = 1; repeat (200) cyc(); wait_mode = 0;
    meas(20000, k);
    check("R8 period extended by freeze", 600 + k, 16 * SPAN + 500);

    // R12: ratio drop below current phase
    do_reset(); div_sel = 1;
    svc_once(); repeat (50) cyc();
    div_sel = 0; meas(20000, k);
    check("R12 ratio drop fires at once", 50 + k, 51 + (SPAN - 1) * 16);

    // R10: service write on the underflow cycle (interrupt mode)
    do_reset();
    svc_once(); repeat (16 * SPAN - 1) cyc();
    svc_once();
    check("R10 no irq on coincident service", int'(irq), 0);
    meas(20000, k);
    check("R10 reload period", k, 16 * SPAN);

    // R6/R7: clear-write ignored, then reset mode
    do_reset();
    mode_wr = 1; mode_wdata = 0; cyc(); mode_wr = 0;
    svc_once(); meas(20000, k);
    check("R6 zero write keeps interrupt mode", int'(irq), 1);
    mode_wr = 1; mode_wdata = 1; cyc(); mode_wr = 0;
    meas(20000, k);
    check("R7 reset event at underflow", int'(rst_req_n), 0);
    check("R7 no irq in reset mode", int'(irq), 0);
    check("R7 reset timing", k + 1, 16 * SPAN);
    lows = 1;
    while (!rst_req_n && lows < 20) begin
      cyc(); if (!rst_req_n) lows++;
    end
    check("R7 reset pulse length", lows, RLEN);
    idle_watch(2000, ev);
    check("R7 idle after internal reset", ev, 0);
    svc_once(); meas(20000, k);
    check("R7 mode cleared by internal reset", int'(irq), 1);
    check("R7 prescaler cleared by internal reset", k, 16 * SPAN);

    // R6: set then attempted clear
    mode_wr = 1; mode_wdata = 1; cyc();
    mode_wdata = 0; cyc(); mode_wr = 0;
    meas(20000, k);
    check("R6 mode cannot be cleared", int'(rst_req_n), 0);

    // R11: writes during the reset pulse are ignored
    svc_wr = 1; mode_wr = 1; mode_wdata = 1; cyc();
    svc_wr = 0; mode_wr = 0;
    while (!rst_req_n) cyc();
    idle_watch(3000, ev);
    check("R11 writes ignored during pulse", ev, 0);

    // R10 in reset mode
    do_reset();
    mode_wr = 1; mode_wdata = 1; cyc(); mode_wr = 0;
    svc_once(); repeat (16 * SPAN - 1) cyc();
    svc_once();
    check("R10 no reset on coincident service", int'(rst_req_n), 1);
    meas(20000, k);
    check("R10 reset after full reload", k, 16 * SPAN);
    while (!rst_req_n) cyc();

    // random phase against the model
    do_reset();
    for (int i = 0; i < 40000; i++) begin
      svc_wr = ($urandom % 400) == 0;
      mode_wr = ($urandom % 3000) == 0;
      mode_wdata = 1'($urandom % 2);
      if (($urandom % 500) == 0) stop_mode = ~stop_mode;
      if (($urandom % 500) == 0) wait_mode = ~wait_mode;
      if (($urandom % 700) == 0) cpu_src = 2'($urandom % 4);
      if (($urandom % 700) == 0) div_sel = ~div_sel;
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule